// File: doc/BRIEF.md
# LIN Receive Frame Request Sequencer

This block lets a LIN master fetch one response frame from a slave, driven only by a short packed descriptor. The descriptor arrives four bytes at a time on a byte-stream input, the way a memory-to-peripheral DMA channel would feed it. It tells the block which protected identifier to send, how many data bytes the slave will return, whether and how the checksum is judged, and how long the master waits for the answer.

After a descriptor is taken, the block drives the header itself. It holds the line dominant for the break, then asks an external serial transmitter for the synch byte and then the identifier. Once the identifier has gone out, the block starts a response timer and forwards each byte from the serial receiver to a receive byte output: first the data bytes, then the checksum byte, which is flagged as last. A one-cycle done pulse closes a complete frame. A wrong direction bit, an expired timer or a checksum mismatch each raise their own flag.

Bit-level shifting stays in the external transmitter and receiver. The block only sees whole bytes and a one-pulse-per-bit-time tick.

Top module: `lin_rx_frame_seq`

## Requirements
- R1: Descriptor bytes are taken in order on cycles where desc_valid and desc_ready are both high. Byte 0 is the protected identifier and is sent unchanged. Byte 1 is the data byte count N. Byte 2 has bit 7 = checksum enable, bit 6 = enhanced checksum (identifier included), bit 5 = direction, bit 4 unused, and bits 3:0 = timeout bits 11:8. Byte 3 holds timeout bits 7:0.
- R2: After reset the block is idle: desc_ready is 1, and brk_out, tx_req, out_valid, done and all error flags are 0.
- R3: A descriptor whose direction bit is 1 sets err_dir. No break or transmit request follows, and the block stays idle and ready for the next descriptor.
- R4: Header order. brk_out goes high the cycle after the descriptor is registered. It stays high until the BREAK_BITS-th bit_tick (13 by default) has been consumed. In the next cycle tx_req is high with tx_data = 0x55 until tx_done. Then tx_req stays high with tx_data = the identifier until tx_done.
- R5: rx_valid bytes that arrive outside the response window (header or idle) are not forwarded: out_valid stays 0.
- R6: During the response, each rx_valid byte appears in the same cycle on out_valid/out_data. Exactly N+1 bytes are forwarded, and out_last marks the (N+1)-th. When N = 0 the first byte is last.
- R7: done is high for exactly one cycle, in the cycle after the last byte was forwarded. The block is then idle.
- R8: The timer loads the 12-bit timeout when the identifier's tx_done is consumed and counts down once per bit_tick during the response. On the tick that brings it to zero (a value of 0 expires on the first tick), err_timeout is set, the block returns to idle and no done is given. A non-last byte arriving on the same cycle as that tick takes priority.
- R9: With checksum enable 1, err_csum is set together with done when the last byte differs from the inverted 8-bit carry-wrapped sum of the data bytes, with the identifier added first when the enhanced bit is 1. With checksum enable 0, err_csum stays 0.
- R10: Error flags hold until the next descriptor is registered, and are cleared then.
- R11: desc_ready is 0 from the break until the frame ends, so descriptor bytes offered meanwhile are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor byte offered |
| desc_data | input | 8 | Descriptor byte |
| desc_ready | output | 1 | Descriptor byte can be taken (idle only) |
| bit_tick | input | 1 | One pulse per bit time |
| brk_out | output | 1 | Hold the line dominant (break) |
| tx_req | output | 1 | Request transmission of tx_data |
| tx_data | output | 8 | Byte to transmit (synch or identifier) |
| tx_done | input | 1 | Transmitter finished the requested byte |
| rx_valid | input | 1 | Received byte available (one-cycle pulse) |
| rx_data | input | 8 | Received byte |
| out_valid | output | 1 | Response byte forwarded |
| out_data | output | 8 | Forwarded response byte |
| out_last | output | 1 | Forwarded byte is the checksum byte |
| done | output | 1 | One-cycle pulse: frame complete |
| err_dir | output | 1 | Descriptor rejected: direction bit set |
| err_timeout | output | 1 | Response timer expired |
| err_csum | output | 1 | Checksum compare failed |

## Verification
The assertions assume well-behaved neighbours. tx_done pulses only while tx_req is high, and rx_valid and bit_tick are single-cycle pulses that the receiver and divider produce between edges. Under these conditions, the transmit byte stays steady for as long as it is requested, and an expiring timer always leaves the block idle with err_timeout set. The stimulus follows the same rules. The transmitter model raises tx_done for one cycle only after seeing tx_req for three cycles, the tick divider fires every fourth cycle, and receive bytes are single pulses with idle gaps. The one deliberate violation is noise: descriptor and receive bytes offered during the break, to show they are dropped.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int LEN_W   = 8;
    localparam int TMO_W   = 12;
    localparam int TMO_HIW = TMO_W - BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_SYNC,
        ST_PID,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] pid;
        logic [LEN_W-1:0]  n_data;
        logic              cs_en;
        logic              cs_enh;
        logic              dir_tx;
        logic [TMO_W-1:0]  tmo;
    } frame_desc_t;

    // 8-bit add with the carry wrapped back into bit 0
    function automatic logic [BYTE_W-1:0] csum_fold(input logic [BYTE_W-1:0] acc,
                                                     input logic [BYTE_W-1:0] b);
        logic [BYTE_W:0] s;
        s = {1'b0, acc} + {1'b0, b};
        return s[BYTE_W-1:0] + {{(BYTE_W-1){1'b0}}, s[BYTE_W]};
    endfunction

endpackage

// File: rtl/lin_desc_collect.sv
module lin_desc_collect
    import lin_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output frame_desc_t       out_desc
);
    localparam int NBYTES = 4;
    localparam int IDX_W  = $clog2(NBYTES);

    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] hold [NBYTES-1];
    logic              take;

    assign in_ready = en && !out_valid;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            out_valid <= 1'b0;
            out_desc  <= '0;
            for (int i = 0; i < NBYTES - 1; i++) hold[i] <= '0;
        end else begin
            out_valid <= 1'b0;
            if (take) begin
                if (idx == IDX_W'(NBYTES - 1)) begin
                    idx             <= '0;
                    out_valid       <= 1'b1;
                    out_desc.pid    <= hold[0];
                    out_desc.n_data <= hold[1];
                    out_desc.cs_en  <= hold[2][7];
                    out_desc.cs_enh <= hold[2][6];
                    out_desc.dir_tx <= hold[2][5];
                    out_desc.tmo    <= {hold[2][TMO_HIW-1:0], in_data};
                end else begin
                    hold[idx] <= in_data;
                    idx       <= idx + 1'b1;
                end
            end
        end
    end

    AST_DESC_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);  // R1

endmodule

// File: rtl/lin_resp_timer.sv
module lin_resp_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = run && tick && (cnt <= W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc
    import lin_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [BYTE_W-1:0] init_val,
    input  logic              add,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [BYTE_W-1:0] expect_byte
);
    logic [BYTE_W-1:0] sum;

    assign expect_byte = ~sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (init) begin
            sum <= init_val;
        end else if (add) begin
            sum <= csum_fold(sum, add_byte);
        end
    end

endmodule

// File: rtl/lin_rx_frame_seq.sv
module lin_rx_frame_seq
    import lin_seq_pkg::*;
#(
    parameter int               BREAK_BITS = 13,
    parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h55
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        desc_valid,
    input  logic [7:0]  desc_data,
    output logic        desc_ready,
    input  logic        bit_tick,
    output logic        brk_out,
    output logic        tx_req,
    output logic [7:0]  tx_data,
    input  logic        tx_done,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        done,
    output logic        err_dir,
    output logic        err_timeout,
    output logic        err_csum
);
    localparam int BRK_W = $clog2(BREAK_BITS + 1);
    localparam int REM_W = LEN_W + 1;

    seq_state_e        state;
    frame_desc_t       desc;
    logic              desc_v;
    logic [BRK_W-1:0]  brk_cnt;
    logic [REM_W-1:0]  remain;
    logic              resp_take;
    logic              is_last;
    logic              pid_sent;
    logic              tmo_hit;
    logic [BYTE_W-1:0] csum_exp;

    lin_desc_collect u_desc (
        .clk       (clk),
        .rst       (rst),
        .en        (state == ST_IDLE),
        .in_valid  (desc_valid),
        .in_data   (desc_data),
        .in_ready  (desc_ready),
        .out_valid (desc_v),
        .out_desc  (desc)
    );

    assign pid_sent = (state == ST_PID) && tx_done;

    lin_resp_timer #(.W(TMO_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (pid_sent),
        .load_val (desc.tmo),
        .run      (state == ST_RESP),
        .tick     (bit_tick),
        .expired  (tmo_hit)
    );

    assign resp_take = (state == ST_RESP) && rx_valid;
    assign is_last   = (remain == REM_W'(1));

    lin_csum_acc u_csum (
        .clk         (clk),
        .rst         (rst),
        .init        (pid_sent),
        .init_val    (desc.cs_enh ? desc.pid : '0),
        .add         (resp_take && !is_last),
        .add_byte    (rx_data),
        .expect_byte (csum_exp)
    );

    assign brk_out   = (state == ST_BREAK);
    assign tx_req    = (state == ST_SYNC) || (state == ST_PID);
    assign tx_data   = (state == ST_SYNC) ? SYNC_BYTE : desc.pid;
    assign out_valid = resp_take;
    assign out_data  = rx_data;
    assign out_last  = resp_take && is_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            brk_cnt     <= '0;
            remain      <= '0;
            done        <= 1'b0;
            err_dir     <= 1'b0;
            err_timeout <= 1'b0;
            err_csum    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (desc_v) begin
                        err_timeout <= 1'b0;
                        err_csum    <= 1'b0;
                        err_dir     <= desc.dir_tx;
                        brk_cnt     <= '0;
                        if (!desc.dir_tx) state <= ST_BREAK;
                    end
                end
                ST_BREAK: begin
                    if (bit_tick) begin
                        if (brk_cnt == BRK_W'(BREAK_BITS - 1)) state <= ST_SYNC;
                        else brk_cnt <= brk_cnt + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (tx_done) state <= ST_PID;
                end
                ST_PID: begin
                    if (tx_done) begin
                        state  <= ST_RESP;
                        remain <= {1'b0, desc.n_data} + REM_W'(1);
                    end
                end
                ST_RESP: begin
                    if (rx_valid) begin
                        if (is_last) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                            if (desc.cs_en && rx_data != csum_exp) err_csum <= 1'b1;
                        end else begin
                            remain <= remain - 1'b1;
                        end
                    end else if (tmo_hit) begin
                        err_timeout <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DIR_NO_HDR: assert property (@(posedge clk) disable iff (rst)
        $rose(err_dir) |-> desc_ready && !brk_out && !tx_req);  // R3
    AST_SYNC_AFTER_BREAK: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_out) |-> tx_req && tx_data == SYNC_BYTE);  // R4
    AST_TXDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done) |=> $stable(tx_data));  // R4
    AST_NO_FWD_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !tx_req && !brk_out && !desc_ready);  // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R7
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_last));  // R7
    AST_TMO_EXIT: assert property (@(posedge clk) disable iff (rst)
        (tmo_hit && !rx_valid) |=> err_timeout && desc_ready);  // R8
    AST_CSUM_OFF: assert property (@(posedge clk) disable iff (rst)
        (done && !desc.cs_en) |-> !err_csum);  // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (brk_out || tx_req) |-> !desc_ready);  // R11

endmodule

// File: tb/sim_lin_rx_frame_seq.sv
`timescale 1ns/100ps
module sim_lin_rx_frame_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       desc_valid = 1'b0;
    logic [7:0] desc_data = '0;
    logic       desc_ready;
    logic       bit_tick = 1'b0;
    logic       brk_out;
    logic       tx_req;
    logic [7:0] tx_data;
    logic       tx_done = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       done;
    logic       err_dir;
    logic       err_timeout;
    logic       err_csum;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int ticks_seen = 0;
    int hdr_cnt  = 0;
    int txc      = 0;
    int div      = 0;
    logic [7:0] hdr_log [64];

    always #2.5 clk = ~clk;

    lin_rx_frame_seq u0 (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_data(desc_data), .desc_ready(desc_ready),
        .bit_tick(bit_tick), .brk_out(brk_out),
        .tx_req(tx_req), .tx_data(tx_data), .tx_done(tx_done),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .done(done), .err_dir(err_dir), .err_timeout(err_timeout), .err_csum(err_csum)
    );

    // Bit divider and transmitter model, updated 1 ns after each edge
    always @(posedge clk) begin
        #1;
        cycles++;
        if (bit_tick) ticks_seen++;
        bit_tick = (div == 3);
        div = (div + 1) % 4;
        if (rst) begin
            tx_done = 1'b0;
            txc = 0;
        end else if (tx_done) begin
            tx_done = 1'b0;
            txc = 0;
        end else if (tx_req) begin
            txc++;
            if (txc == 3) begin
                hdr_log[hdr_cnt % 64] = tx_data;
                hdr_cnt++;
                tx_done = 1'b1;
            end
        end else begin
            txc = 0;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_ck(input logic enh, input logic [7:0] pid,
                                          input int n, input logic [7:0] d [8]);
        int s;
        s = enh ? int'(pid) : 0;
        for (int i = 0; i < n; i++) begin
            s = s + int'(d[i]);
            if (s > 255) s = s - 255;
        end
        return ~(8'(s));
    endfunction

    task automatic send_desc(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input logic [7:0] b3);
        logic [7:0] bs [4];
        bs = '{b0, b1, b2, b3};
        for (int i = 0; i < 4; i++) begin
            while (!desc_ready) step();
            desc_data  = bs[i];
            desc_valid = 1'b1;
            step();
            desc_valid = 1'b0;
        end
    endtask

    task automatic wait_hdr(input int target);
        while (!(hdr_cnt >= target && !tx_done)) step();
    endtask

    // Complete frame: header, N data bytes, checksum byte
    task automatic run_frame(input logic [7:0] pid, input int n, input logic [7:0] ctl,
                             input logic [7:0] d [8], input logic [7:0] ck,
                             input logic exp_cerr, input logic noise, input string tag);
        int base;
        int nb;
        int pt;
        base = hdr_cnt;
        send_desc(pid, 8'(n), ctl, 8'hFF);
        step();
        chk(brk_out == 1'b1, "R4", {tag, " break starts"}, brk_out, 1);
        chk(err_dir == 0 && err_csum == 0 && err_timeout == 0, "R10",
            {tag, " flags cleared"}, {err_dir, err_csum, err_timeout}, 0);
        nb = 0;
        while (brk_out) begin
            if (noise) begin
                desc_data  = 8'h3A;
                desc_valid = 1'b1;
                rx_data    = 8'hC3;
                rx_valid   = 1'b1;
                #0.5;
                chk(desc_ready == 1'b0, "R11", {tag, " busy desc_ready"}, desc_ready, 0);
                chk(out_valid == 1'b0, "R5", {tag, " no forward in header"}, out_valid, 0);
            end
            pt = ticks_seen;
            step();
            if (ticks_seen != pt) nb++;
        end
        desc_valid = 1'b0;
        rx_valid   = 1'b0;
        chk(nb == 13, "R4", {tag, " break bit times"}, nb, 13);
        chk(tx_req && tx_data == 8'h55, "R4", {tag, " synch requested"}, tx_data, 8'h55);
        wait_hdr(base + 2);
        chk(hdr_log[base % 64] == 8'h55, "R4", {tag, " first header byte"}, hdr_log[base % 64], 8'h55);
        chk(hdr_log[(base + 1) % 64] == pid, "R1", {tag, " identifier sent"},
            hdr_log[(base + 1) % 64], pid);
        for (int i = 0; i <= n; i++) begin
            rx_data  = (i < n) ? d[i] : ck;
            rx_valid = 1'b1;
            #0.5;
            chk(out_valid && out_data == rx_data, "R6", {tag, " byte forwarded"}, out_data, rx_data);
            chk(out_last == (i == n), "R6", {tag, " last marker"}, out_last, (i == n));
            step();
            rx_valid = 1'b0;
            if (i == n) begin
                chk(done == 1'b1, "R7", {tag, " done pulse"}, done, 1);
                chk(err_csum == exp_cerr, "R9", {tag, " checksum verdict"}, err_csum, exp_cerr);
                step();
                chk(done == 1'b0, "R7", {tag, " done single cycle"}, done, 0);
                chk(desc_ready == 1'b1, "R7", {tag, " back to idle"}, desc_ready, 1);
            end else begin
                chk(done == 1'b0, "R6", {tag, " no early done"}, done, 0);
                step();
            end
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        step();
        chk(desc_ready == 1'b1, "R2", "reset desc_ready", desc_ready, 1);
        chk(!brk_out && !tx_req && !out_valid && !done, "R2", "reset outputs",
            {brk_out, tx_req, out_valid, done}, 0);
        chk(!err_dir && !err_timeout && !err_csum, "R2", "reset flags",
            {err_dir, err_timeout, err_csum}, 0);
    endtask

    task automatic test_classic();
        logic [7:0] d [8] = '{8'h12, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run_frame(8'h8C, 2, 8'h8F, d, ref_ck(1'b0, 8'h8C, 2, d), 1'b0, 1'b0, "classic");
    endtask

    task automatic test_enh_bad_n0();
        logic [7:0] d [8] = '{default: 8'h00};
        run_frame(8'hC1, 0, 8'hCF, d, ref_ck(1'b1, 8'hC1, 0, d) ^ 8'h01, 1'b1, 1'b0, "n0 bad");
    endtask

    task automatic test_enh_good();
        logic [7:0] d [8] = '{8'hFF, 8'hFE, 8'h80, 8'h81, 8'h00, 8'h00, 8'h00, 8'h00};
        run_frame(8'h50, 4, 8'hCF, d, ref_ck(1'b1, 8'h50, 4, d), 1'b0, 1'b1, "enh good");
    endtask

    task automatic test_cs_off();
        logic [7:0] d [8] = '{8'hAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run_frame(8'h23, 1, 8'h0F, d, 8'h00, 1'b0, 1'b0, "cs off");
    endtask

    task automatic test_dir_reject();
        int base;
        base = hdr_cnt;
        send_desc(8'h11, 8'h02, 8'hAF, 8'hFF);
        step();
        chk(err_dir == 1'b1, "R3", "direction error flag", err_dir, 1);
        repeat (20) begin
            step();
            if (brk_out || tx_req) break;
        end
        chk(!brk_out && !tx_req && hdr_cnt == base, "R3", "no header after reject",
            {brk_out, tx_req}, 0);
        chk(desc_ready == 1'b1, "R3", "ready after reject", desc_ready, 1);
        chk(err_dir == 1'b1, "R10", "direction flag held", err_dir, 1);
    endtask

    task automatic test_timeout();
        int base;
        int t0;
        logic saw_done;
        base = hdr_cnt;
        saw_done = 1'b0;
        send_desc(8'h3C, 8'h03, 8'h80, 8'h05);
        wait_hdr(base + 2);
        t0 = ticks_seen;
        rx_data  = 8'h77;
        rx_valid = 1'b1;
        step();
        rx_valid = 1'b0;
        while (ticks_seen - t0 < 5) begin
            if (done) saw_done = 1'b1;
            chk(err_timeout == 1'b0, "R8", "no early timeout", err_timeout, 0);
            step();
        end
        chk(err_timeout == 1'b1, "R8", "timeout at fifth tick", err_timeout, 1);
        chk(desc_ready == 1'b1, "R8", "idle after timeout", desc_ready, 1);
        chk(saw_done == 1'b0 && done == 1'b0, "R8", "no done after timeout", done, 0);
        rx_data  = 8'h42;
        rx_valid = 1'b1;
        #0.5;
        chk(out_valid == 1'b0, "R5", "idle byte not forwarded", out_valid, 0);
        step();
        rx_valid = 1'b0;
    endtask

    initial begin
        test_reset();
        test_classic();
        test_enh_bad_n0();
        test_cs_off();
        test_dir_reject();
        test_enh_good();
        test_timeout();
        test_classic();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule